// File: doc/BRIEF.md
# Isochronous Receive Context Packet Matcher

This block sits beside one isochronous receive DMA context and decides, header by header, whether an incoming isochronous packet belongs to that context. Software programs a 32-bit match word through a small write port. The word holds a channel number, a mask with one enable bit per tag value, a filter that adds a sync condition for tag 01, a 4-bit sync value for sync waits, and a 15-bit cycle-time value at which reception can be started.

Once the run bit is high, the context becomes enabled at once. If cycle-match-enable is also set, the context instead stays off until the cycle-timer input reaches the stored cycle value. At that point the block asks for cycle-match-enable to be cleared and latches the context on. Each header strobe then produces a registered accept-or-drop decision one clock later. When the current descriptor's wait field is 11, packets whose sync does not equal the stored value are dropped until the first one that does.

Top module: `iso_rx_ctx_match`

## Requirements
- R1: After reset the match word reads 0, `ctx_en_o` is low and `dec_vld_o` is low.
- R2: Bits 27 and 7 of the match word always read 0, and writing 1 to them has no effect.
- R3: Every other bit of the match word reads back the value last written to it, from the clock after the write onward. The fields are tag enables in bits 31..28 (bit 31 enables tag 11, bit 30 tag 10, bit 29 tag 01, bit 28 tag 00), the cycle value in bits 26..12, sync in bits 11..8, the tag-01 filter in bit 6 and the channel in bits 5..0.
- R4: With `run_i` high and `cme_i` low, `ctx_en_o` goes high one clock after `run_i` rises. Whenever `run_i` is low, `ctx_en_o` is low from the next clock onward.
- R5: With `run_i` and `cme_i` high, `ctx_en_o` stays low until {`timer_sec_i[1:0]`, `timer_cnt_i`} equals bits 26..12. During that matching cycle `cme_clr_o` is high. `ctx_en_o` rises on the next clock and then stays high, whatever the timer does, until `run_i` falls.
- R6: A header strobe with `run_i` high produces `dec_vld_o` for exactly one clock, on the clock after the strobe. No decision is produced while `run_i` is low.
- R7: A header whose channel differs from bits 5..0 is dropped.
- R8: A packet with tag t is accepted only if the tag-enable bit for t is set.
- R9: When bit 6 and the tag-01 enable are both set, a tag-01 packet is accepted only if sync[3:2] is 00. Packets with other tags are not affected by bit 6.
- R10: While `wait_i` is 11, packets whose sync differs from bits 11..8 are dropped until one packet with equal sync is accepted. After that, sync is ignored until a header arrives with `wait_i` not 11, or until `run_i` falls.
- R11: A header that arrives while `ctx_en_o` is low gets a decision of drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Write strobe for the match word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Current match word |
| timer_sec_i | input | 7 | Cycle-timer seconds field |
| timer_cnt_i | input | 13 | Cycle-timer cycle count |
| run_i | input | 1 | Context run bit |
| cme_i | input | 1 | Cycle-match-enable bit |
| cme_clr_o | output | 1 | Request to clear cycle-match-enable |
| ctx_en_o | output | 1 | Context enabled |
| hdr_vld_i | input | 1 | Header valid strobe |
| hdr_chan_i | input | 6 | Packet channel |
| hdr_tag_i | input | 2 | Packet tag |
| hdr_sync_i | input | 4 | Packet sync |
| wait_i | input | 2 | Wait field of current descriptor |
| dec_vld_o | output | 1 | Decision valid |
| dec_acc_o | output | 1 | 1 = accept, 0 = drop |

## Verification
A corrupted match-word bit appears on `reg_rdata_o` in the clock after the write. It also shows up in the very next decision of any header that uses that field. If the context-enable state is wrong, it is visible directly on `ctx_en_o` one clock after the `run_i` or timer event, and it turns the next decision into a drop or an accept. A stuck sync-wait flag only shows once a header arrives under wait 11: either the first matching packet is dropped, or a second packet with a different sync is dropped, and this happens on the decision one clock after that header.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  localparam int CH_W   = 6;
  localparam int TAG_W  = 2;
  localparam int SYNC_W = 4;
  localparam int SEC_W  = 7;
  localparam int CNT_W  = 13;
  localparam int CYC_W  = 2 + CNT_W;
  localparam int NTAG   = 1 << TAG_W;

  typedef struct packed {
    logic [NTAG-1:0]   tag_en;
    logic              rsvd_hi;
    logic [CYC_W-1:0]  cyc;
    logic [SYNC_W-1:0] sync;
    logic              rsvd_lo;
    logic              t1_filt;
    logic [CH_W-1:0]   chan;
  } match_cfg_t;

  localparam logic [31:0] WR_MASK = 32'hF7FF_FF7F;
  localparam logic [TAG_W-1:0]  TAG_T1    = 2'b01;
  localparam logic [1:0]        WAIT_SYNC = 2'b11;
endpackage

// File: rtl/iso_rx_match_reg.sv
module iso_rx_match_reg
  import iso_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output match_cfg_t  cfg_o
);
  logic [31:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & WR_MASK;
  end

  assign cfg_o = match_cfg_t'(q);

  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q[27] && !q[7]);
  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q == ($past(wdata_i) & WR_MASK));
endmodule

// File: rtl/iso_rx_ctx_gate.sv
module iso_rx_ctx_gate
  import iso_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cme_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CYC_W-1:0] cyc_i,
  output logic             cme_clr_o,
  output logic             ctx_en_o
);
  logic hit, en_q;
  logic unused_sec;

  assign unused_sec = ^sec_i[SEC_W-1:2];
  assign hit        = ({sec_i[1:0], cnt_i} == cyc_i);
  assign cme_clr_o  = run_i && !en_q && cme_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               en_q <= 1'b0;
    else if (!run_i)           en_q <= 1'b0;
    else if (!en_q && (!cme_i || hit)) en_q <= 1'b1;
  end

  assign ctx_en_o = en_q;

  a_r4_run_low_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !ctx_en_o);
  a_r5_hold_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_en_o && run_i) |=> ctx_en_o);
  a_r5_wait_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cme_i && !ctx_en_o && !cme_clr_o) |=> !ctx_en_o);
  a_r5_clr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cme_clr_o |=> ctx_en_o);
endmodule

// File: rtl/iso_rx_pkt_filter.sv
module iso_rx_pkt_filter
  import iso_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  match_cfg_t        cfg_i,
  input  logic              run_i,
  input  logic              ctx_en_i,
  input  logic              hdr_vld_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [SYNC_W-1:0] sync_i,
  input  logic [1:0]        wait_i,
  output logic              dec_vld_o,
  output logic              dec_acc_o
);
  logic chan_ok, tag_ok, filt_ok, sync_ok, waiting, acc;
  logic sdone_q, vld_q, acc_q;

  assign waiting = (wait_i == WAIT_SYNC) && !sdone_q;
  assign chan_ok = (chan_i == cfg_i.chan);
  assign tag_ok  = cfg_i.tag_en[tag_i];
  // tag-01 extra rule only when both filter and its enable are set
  assign filt_ok = !(tag_i == TAG_T1 && cfg_i.t1_filt && cfg_i.tag_en[TAG_T1])
                   || (sync_i[SYNC_W-1:SYNC_W-2] == 2'b00);
  assign sync_ok = !waiting || (sync_i == cfg_i.sync);
  assign acc     = ctx_en_i && chan_ok && tag_ok && filt_ok && sync_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0; acc_q <= 1'b0; sdone_q <= 1'b0;
    end else begin
      vld_q <= hdr_vld_i && run_i;
      acc_q <= hdr_vld_i && run_i && acc;
      if (!run_i) sdone_q <= 1'b0;
      else if (hdr_vld_i) begin
        if (wait_i != WAIT_SYNC) sdone_q <= 1'b0;
        else if (acc)            sdone_q <= 1'b1;
      end
    end
  end

  assign dec_vld_o = vld_q;
  assign dec_acc_o = acc_q;

  a_r6_dec_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_vld_i && run_i) |=> dec_vld_o);
  a_r6_no_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_vld_i && run_i) |=> !dec_vld_o);
  a_r7_chan_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_vld_i && chan_i != cfg_i.chan) |=> !dec_acc_o);
  a_r10_sync_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_vld_i && waiting && sync_i != cfg_i.sync) |=> !dec_acc_o);
  a_r11_off_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_vld_i && !ctx_en_i) |=> !dec_acc_o);
endmodule

// File: rtl/iso_rx_ctx_match.sv
module iso_rx_ctx_match
  import iso_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic [6:0]  timer_sec_i,
  input  logic [12:0] timer_cnt_i,
  input  logic        run_i,
  input  logic        cme_i,
  output logic        cme_clr_o,
  output logic        ctx_en_o,
  input  logic        hdr_vld_i,
  input  logic [5:0]  hdr_chan_i,
  input  logic [1:0]  hdr_tag_i,
  input  logic [3:0]  hdr_sync_i,
  input  logic [1:0]  wait_i,
  output logic        dec_vld_o,
  output logic        dec_acc_o
);
  match_cfg_t cfg;
  logic       ctx_en;

  iso_rx_match_reg u_reg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .wdata_i(reg_wdata_i), .cfg_o(cfg)
  );

  iso_rx_ctx_gate u_gate (
    .clk_i, .rst_ni, .run_i, .cme_i, .sec_i(timer_sec_i), .cnt_i(timer_cnt_i),
    .cyc_i(cfg.cyc), .cme_clr_o, .ctx_en_o(ctx_en)
  );

  iso_rx_pkt_filter u_filt (
    .clk_i, .rst_ni, .cfg_i(cfg), .run_i, .ctx_en_i(ctx_en),
    .hdr_vld_i, .chan_i(hdr_chan_i), .tag_i(hdr_tag_i), .sync_i(hdr_sync_i),
    .wait_i, .dec_vld_o, .dec_acc_o
  );

  assign reg_rdata_o = cfg;
  assign ctx_en_o    = ctx_en;

  a_r1_acc_has_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_acc_o |-> dec_vld_o);
endmodule

// File: tb/sim_iso_rx_ctx_match.sv
module sim_iso_rx_ctx_match;
  logic        clk = 0, rst_ni = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [6:0]  tsec = 0;
  logic [12:0] tcnt = 0;
  logic        run = 0, cme = 0, cme_clr, ctx_en;
  logic        hvld = 0;
  logic [5:0]  hch = 0;
  logic [1:0]  htag = 0, hwait = 0;
  logic [3:0]  hsync = 0;
  logic        dvld, dacc;

  int checks = 0, fails = 0;
  logic [31:0] mreg = 0;
  bit mctx = 0, msd = 0;

  always #10 clk = ~clk;

  iso_rx_ctx_match u0 (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .timer_sec_i(tsec), .timer_cnt_i(tcnt),
    .run_i(run), .cme_i(cme), .cme_clr_o(cme_clr), .ctx_en_o(ctx_en),
    .hdr_vld_i(hvld), .hdr_chan_i(hch), .hdr_tag_i(htag), .hdr_sync_i(hsync),
    .wait_i(hwait), .dec_vld_o(dvld), .dec_acc_o(dacc)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    reg_we = 1; reg_wdata = v;
    @(negedge clk);
    reg_we = 0;
    mreg = v & 32'hF7FF_FF7F;
  endtask

  function automatic bit exp_acc(logic [5:0] c, logic [1:0] t, logic [3:0] s, logic [1:0] w);
    bit ok;
    ok = mctx && (c == mreg[5:0]) && mreg[28 + t];
    if (t == 2'b01 && mreg[6] && mreg[29] && s[3:2] != 2'b00) ok = 0;
    if (w == 2'b11 && !msd && s != mreg[11:8]) ok = 0;
    return ok;
  endfunction

  task automatic hdr(string req, logic [5:0] c, logic [1:0] t, logic [3:0] s, logic [1:0] w);
    bit e;
    e = exp_acc(c, t, s, w);
    hvld = 1; hch = c; htag = t; hsync = s; hwait = w;
    @(negedge clk);
    hvld = 0;
    if (run) begin
      if (w != 2'b11) msd = 0;
      else if (e) msd = 1;
    end
    chk(req, {31'd0, dvld}, {31'd0, run});
    chk(req, {31'd0, dacc}, {31'd0, run & e});
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1394));
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 ctx_en", {31'd0, ctx_en}, 0);
    chk("R1 dvld", {31'd0, dvld}, 0);
    // R2 / R3
    wr(32'hFFFF_FFFF);
    chk("R2 rsvd", reg_rdata, 32'hF7FF_FF7F);
    wr(32'h0800_0080);
    chk("R2 rsvd only", reg_rdata, 0);
    wr(32'hA5A5_5A5A);
    chk("R3 readback", reg_rdata, 32'hA5A5_5A5A & 32'hF7FF_FF7F);
    // R6: run low gives no decision
    wr(32'hF000_0005);
    hdr("R6 run low", 6'd5, 2'b00, 4'h0, 2'b00);
    // R11: header in same cycle run rises
    run = 1;
    chk("R4 pre", {31'd0, ctx_en}, 0);
    hdr("R11 ctx off", 6'd5, 2'b00, 4'h0, 2'b00);
    mctx = 1;
    chk("R4 ctx_en", {31'd0, ctx_en}, 1);
    // R7 / R8
    hdr("R7 chan", 6'd6, 2'b00, 4'h0, 2'b00);
    hdr("R8 all tags", 6'd5, 2'b11, 4'h3, 2'b00);
    wr(32'h4000_0005);
    hdr("R8 tag10 on", 6'd5, 2'b10, 4'h0, 2'b00);
    hdr("R8 tag11 off", 6'd5, 2'b11, 4'h0, 2'b00);
    hdr("R8 tag00 off", 6'd5, 2'b00, 4'h0, 2'b00);
    // R9
    wr(32'h3000_0045);
    hdr("R9 t1 ok", 6'd5, 2'b01, 4'h3, 2'b00);
    hdr("R9 t1 blocked", 6'd5, 2'b01, 4'h4, 2'b00);
    hdr("R9 t0 free", 6'd5, 2'b00, 4'hC, 2'b00);
    wr(32'h2000_0005);
    hdr("R9 filt off", 6'd5, 2'b01, 4'hC, 2'b00);
    // R10
    wr(32'hF000_0A05);
    hdr("R10 wrong sync", 6'd5, 2'b00, 4'h3, 2'b11);
    hdr("R10 chan miss", 6'd6, 2'b00, 4'hA, 2'b11);
    hdr("R10 match", 6'd5, 2'b00, 4'hA, 2'b11);
    hdr("R10 after", 6'd5, 2'b00, 4'h3, 2'b11);
    hdr("R10 leave", 6'd5, 2'b00, 4'h3, 2'b00);
    hdr("R10 rearm", 6'd5, 2'b00, 4'h3, 2'b11);
    // R4 run low
    run = 0; mctx = 0; msd = 0;
    @(negedge clk);
    chk("R4 off", {31'd0, ctx_en}, 0);
    // R5 cycle match
    wr(32'hF000_0005 | ({17'd0, 2'b10, 13'd100} << 12));
    tsec = 7'h06; tcnt = 13'd99; cme = 1; run = 1;
    chk("R5 no clr", {31'd0, cme_clr}, 0);
    repeat (3) @(negedge clk);
    chk("R5 held off", {31'd0, ctx_en}, 0);
    hdr("R5 drop while off", 6'd5, 2'b00, 4'h0, 2'b00);
    tsec = 7'h12; tcnt = 13'd100;
    #1;
    chk("R5 clr", {31'd0, cme_clr}, 1);
    @(negedge clk);
    cme = 0; mctx = 1;
    chk("R5 on", {31'd0, ctx_en}, 1);
    tcnt = 13'd7;
    repeat (3) @(negedge clk);
    chk("R5 stays", {31'd0, ctx_en}, 1);
    hdr("R5 accept", 6'd5, 2'b00, 4'h0, 2'b00);
    // random
    for (int k = 0; k < 400; k++) begin
      logic [5:0] c; logic [1:0] t, w; logic [3:0] s;
      if (k % 50 == 0) wr(($urandom & 32'hF000_0F40) | 32'h0000_0011);
      c = ($urandom % 4 == 0) ? 6'($urandom) : 6'h11;
      t = 2'($urandom); s = 4'($urandom % 4 == 0 ? mreg[11:8] : $urandom);
      w = ($urandom % 2) ? 2'b11 : 2'($urandom);
      hdr("R8 R9 R10 rand", c, t, s, w);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule